// File: doc/BRIEF.md
# Thermal Sensor Scan Supervisor

This block supervises a set of on-die temperature sensing channels without software involvement. Once scanning is switched on, it waits a programmable interval, then asks an external converter for one 12-bit reading per channel, visiting channel 0 first and ending with the highest channel. Each reading is stored and compared against that channel's programmed limit. A lower code means a hotter die, so a channel is counted as hot when its code is less than or equal to the limit.

Hot readings must repeat on consecutive scans before anything happens. One count sets a per-channel pending flag that drives a single interrupt line. A second count, set separately, latches an overtemperature shutdown. Each channel can send its shutdown to a reset-controller output, to a pin output, or to both. The shutdown outputs share one programmable active level. While any watched channel is hot, the wait between scans switches to a shorter interval. The longer interval returns once no watched channel is hot.

A simple register bus configures the block and reads its state. Writes take effect on the clock edge, and read data is registered one cycle after the read strobe.

Top module: `thermal_supervisor`

## Requirements
- R1: After reset, control, interrupt enable and pending read 0, both debounce counts read 4, the normal interval reads 250 and the fast interval reads 50. The interrupt is low and both shutdown outputs sit at the low-active inactive level, which is 1.
- R2: The register offsets are: control 0x04, enable/routing 0x08, pending 0x0C, reading n at 0x20+4n, limit n at 0x40+4n, interrupt debounce 0x60, shutdown debounce 0x64, normal interval 0x68, fast interval 0x6C. Written values read back.
- R3: Control bit 0 enables scanning. While it is 0, no conversion is requested. The first request follows P cycles after the enabling write, where P is the current interval (0 is treated as 1). Channels are requested in ascending order, and each request is held until acknowledged.
- R4: The register for reading n holds the 12-bit code of channel n's latest conversion.
- R5: A sample is hot when code <= limit. A channel's consecutive-hot count increments on each hot sample and returns to zero on any sample that is not hot.
- R6: Pending bit n sets when enable bit n is 1 and a hot sample brings the count to at least the interrupt debounce (0 treated as 1). The interrupt output is the OR of the pending bits.
- R7: Writing 1 to pending bits 0..N-1 clears them. Pending bit 8 reads 1 while any shutdown is latched, and writes to it have no effect.
- R8: The shutdown for channel n latches when control bit 4+n is 1 and a hot sample brings the count to at least the shutdown debounce (0 treated as 1). Enable bit 4+n sends it to the pin output and bit 8+n sends it to the reset output. A latched shutdown stays set until reset.
- R9: Control bit 8 sets the shutdown active level (1 high, 0 low). While control bit 0 is 0, both shutdown outputs hold the inactive level.
- R10: The fast interval is used after a scan that leaves any channel hot whose enable bit n or control bit 4+n is set. The normal interval is used when no such channel is hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| adc_req | output | 1 | Conversion request, held until acknowledged |
| adc_ch | output | 2 | Channel being converted |
| adc_ack | input | 1 | One-cycle conversion done |
| adc_code | input | 12 | Conversion result, valid with adc_ack |
| irq_o | output | 1 | Interrupt, OR of pending bits |
| shut_rst_o | output | 1 | Shutdown to the reset controller |
| shut_gpio_o | output | 1 | Shutdown to the pin |

## Verification
The assertions assume a well-behaved converter. Acknowledges arrive only while a request is pending and last one cycle. The code is stable alongside the acknowledge. Configuration is rewritten only during the wait between scans. The bench's converter model answers a fixed few cycles after each request and pulses the acknowledge for one cycle. All register writes are made right after a scan has ended, and intervals of 40 cycles or more leave room for them. Any interval that follows a register write is excluded from the timing comparison.

// File: rtl/tsup_pkg.sv
package tsup_pkg;
  localparam int OFF_CTRL   = 'h04;
  localparam int OFF_ROUTE  = 'h08;
  localparam int OFF_PEND   = 'h0C;
  localparam int OFF_DATA   = 'h20;
  localparam int OFF_LIMIT  = 'h40;
  localparam int OFF_IDB    = 'h60;
  localparam int OFF_SDB    = 'h64;
  localparam int OFF_SLOW   = 'h68;
  localparam int OFF_FAST   = 'h6C;
  localparam int BIT_SHUT_STATUS = 8;

  typedef enum logic {SCAN_WAIT, SCAN_CONV} scan_state_e;
endpackage

// File: rtl/tsup_sched.sv
module tsup_sched import tsup_pkg::*; #(
  parameter  int CH_N  = 4,
  parameter  int PER_W = 16,
  localparam int CH_W  = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             scan_en,
  input  logic             hot,
  input  logic [PER_W-1:0] per_slow,
  input  logic [PER_W-1:0] per_fast,
  input  logic             adc_ack,
  output logic             adc_req,
  output logic [CH_W-1:0]  adc_ch,
  output logic             smp_vld
);
  scan_state_e      st_q, st_d;
  logic [PER_W-1:0] tmr_q, tmr_d, per_sel, per_eff;
  logic [CH_W-1:0]  ch_q, ch_d;

  assign per_sel = hot ? per_fast : per_slow;
  assign per_eff = (per_sel == '0) ? PER_W'(1) : per_sel;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    ch_d  = ch_q;
    if (!scan_en) begin
      st_d  = SCAN_WAIT;
      tmr_d = '0;
      ch_d  = '0;
    end else if (st_q == SCAN_WAIT) begin
      if (tmr_q >= per_eff - PER_W'(1)) begin
        st_d  = SCAN_CONV;
        tmr_d = '0;
        ch_d  = '0;
      end else begin
        tmr_d = tmr_q + PER_W'(1);
      end
    end else if (adc_ack) begin
      if (ch_q == CH_W'(CH_N - 1)) begin
        st_d = SCAN_WAIT;
        ch_d = '0;
      end else begin
        ch_d = ch_q + CH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SCAN_WAIT;
      tmr_q <= '0;
      ch_q  <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      ch_q  <= ch_d;
    end
  end

  assign adc_req = (st_q == SCAN_CONV);
  assign adc_ch  = ch_q;
  assign smp_vld = adc_req & adc_ack;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    adc_req && !adc_ack && scan_en |=> adc_req && $stable(adc_ch)); // R3
  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    !scan_en |=> !adc_req); // R3
  AST_CH_ASCENDING: assert property (@(posedge clk) disable iff (!rst_ni)
    smp_vld && scan_en && adc_ch != CH_W'(CH_N - 1) |=> adc_ch == CH_W'($past(adc_ch) + CH_W'(1))); // R3
endmodule

// File: rtl/tsup_chan.sv
module tsup_chan #(
  parameter int CODE_W = 12,
  parameter int DB_W   = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              smp,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] limit,
  input  logic [DB_W-1:0]   int_db,
  input  logic [DB_W-1:0]   shut_db,
  input  logic              irq_en,
  input  logic              src_en,
  output logic              over_o,
  output logic              irq_hit,
  output logic              shut_hit
);
  logic [DB_W-1:0] cnt_q, cnt_d, idb_eff, sdb_eff;
  logic            over_q, over_d, hot_now;

  assign hot_now = (code <= limit);
  assign idb_eff = (int_db  == '0) ? DB_W'(1) : int_db;
  assign sdb_eff = (shut_db == '0) ? DB_W'(1) : shut_db;

  always_comb begin
    cnt_d  = cnt_q;
    over_d = over_q;
    if (smp) begin
      over_d = hot_now;
      if (!hot_now)                cnt_d = '0;
      else if (cnt_q != '1)        cnt_d = cnt_q + DB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (smp) begin
      cnt_q  <= cnt_d;
      over_q <= over_d;
    end
  end

  assign over_o   = over_q;
  assign irq_hit  = smp & hot_now & irq_en & (cnt_d >= idb_eff);
  assign shut_hit = smp & hot_now & src_en & (cnt_d >= sdb_eff);

  AST_COLD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_ni)
    smp && (code > limit) |-> !irq_hit && !shut_hit); // R5
  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_ni)
    smp && (code > limit) |=> cnt_q == '0 && !over_o); // R5
endmodule

// File: rtl/tsup_regs.sv
module tsup_regs import tsup_pkg::*; #(
  parameter  int CH_N   = 4,
  parameter  int CODE_W = 12,
  parameter  int PER_W  = 16,
  parameter  int DB_W   = 8,
  parameter  int ADDR_W = 8,
  parameter  int DATA_W = 32,
  localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic                         clk,
  input  logic                         rst_ni,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  input  logic                         smp_vld,
  input  logic [CH_W-1:0]              smp_ch,
  input  logic [CODE_W-1:0]            smp_code,
  input  logic [CH_N-1:0]              irq_hit,
  input  logic                         shut_any,
  output logic                         scan_en,
  output logic                         shut_pol,
  output logic [CH_N-1:0]              src_en,
  output logic [CH_N-1:0]              irq_en,
  output logic [CH_N-1:0]              to_gpio,
  output logic [CH_N-1:0]              to_rst,
  output logic [CH_N-1:0][CODE_W-1:0]  limit,
  output logic [DB_W-1:0]              int_db,
  output logic [DB_W-1:0]              shut_db,
  output logic [PER_W-1:0]             per_slow,
  output logic [PER_W-1:0]             per_fast,
  output logic                         irq_o
);
  logic [DATA_W-1:0]             ctrl_q, ctrl_d, route_q, route_d, rd_d, rdata_q;
  logic [CH_N-1:0]               pend_q, pend_d, clr;
  logic [CH_N-1:0][CODE_W-1:0]   lim_q, lim_d, res_q, res_d;
  logic [DB_W-1:0]               idb_q, idb_d, sdb_q, sdb_d;
  logic [PER_W-1:0]              slow_q, slow_d, fast_q, fast_d;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  always_comb begin
    ctrl_d  = ctrl_q;
    route_d = route_q;
    lim_d   = lim_q;
    res_d   = res_q;
    idb_d   = idb_q;
    sdb_d   = sdb_q;
    slow_d  = slow_q;
    fast_d  = fast_q;
    clr     = '0;
    if (bus_wr) begin
      if (hit(bus_addr, OFF_CTRL))  ctrl_d  = bus_wdata;
      if (hit(bus_addr, OFF_ROUTE)) route_d = bus_wdata;
      if (hit(bus_addr, OFF_PEND))  clr     = bus_wdata[CH_N-1:0];
      if (hit(bus_addr, OFF_IDB))   idb_d   = bus_wdata[DB_W-1:0];
      if (hit(bus_addr, OFF_SDB))   sdb_d   = bus_wdata[DB_W-1:0];
      if (hit(bus_addr, OFF_SLOW))  slow_d  = bus_wdata[PER_W-1:0];
      if (hit(bus_addr, OFF_FAST))  fast_d  = bus_wdata[PER_W-1:0];
      for (int i = 0; i < CH_N; i++)
        if (hit(bus_addr, OFF_LIMIT + 4 * i)) lim_d[i] = bus_wdata[CODE_W-1:0];
    end
    for (int i = 0; i < CH_N; i++)
      if (smp_vld && smp_ch == CH_W'(i)) res_d[i] = smp_code;
    pend_d = (pend_q & ~clr) | irq_hit;
  end

  always_comb begin
    rd_d = '0;
    if (hit(bus_addr, OFF_CTRL))  rd_d = ctrl_q;
    if (hit(bus_addr, OFF_ROUTE)) rd_d = route_q;
    if (hit(bus_addr, OFF_PEND)) begin
      rd_d[CH_N-1:0]        = pend_q;
      rd_d[BIT_SHUT_STATUS] = shut_any;
    end
    if (hit(bus_addr, OFF_IDB))   rd_d = DATA_W'(idb_q);
    if (hit(bus_addr, OFF_SDB))   rd_d = DATA_W'(sdb_q);
    if (hit(bus_addr, OFF_SLOW))  rd_d = DATA_W'(slow_q);
    if (hit(bus_addr, OFF_FAST))  rd_d = DATA_W'(fast_q);
    for (int i = 0; i < CH_N; i++) begin
      if (hit(bus_addr, OFF_DATA + 4 * i))  rd_d = DATA_W'(res_q[i]);
      if (hit(bus_addr, OFF_LIMIT + 4 * i)) rd_d = DATA_W'(lim_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      route_q <= '0;
      pend_q  <= '0;
      lim_q   <= '0;
      res_q   <= '0;
      idb_q   <= DB_W'(4);
      sdb_q   <= DB_W'(4);
      slow_q  <= PER_W'(250);
      fast_q  <= PER_W'(50);
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      route_q <= route_d;
      pend_q  <= pend_d;
      lim_q   <= lim_d;
      res_q   <= res_d;
      idb_q   <= idb_d;
      sdb_q   <= sdb_d;
      slow_q  <= slow_d;
      fast_q  <= fast_d;
      if (bus_rd) rdata_q <= rd_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign scan_en   = ctrl_q[0];
  assign src_en    = ctrl_q[4 +: CH_N];
  assign shut_pol  = ctrl_q[8];
  assign irq_en    = route_q[0 +: CH_N];
  assign to_gpio   = route_q[4 +: CH_N];
  assign to_rst    = route_q[8 +: CH_N];
  assign limit     = lim_q;
  assign int_db    = idb_q;
  assign shut_db   = sdb_q;
  assign per_slow  = slow_q;
  assign per_fast  = fast_q;
  assign irq_o     = |pend_q;

  AST_IRQ_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(smp_vld)); // R6
endmodule

// File: rtl/thermal_supervisor.sv
module thermal_supervisor #(
  parameter  int CH_N   = 4,
  parameter  int CODE_W = 12,
  parameter  int PER_W  = 16,
  parameter  int DB_W   = 8,
  parameter  int ADDR_W = 8,
  parameter  int DATA_W = 32,
  localparam int CH_W   = (CH_N > 1) ? $clog2(CH_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              adc_req,
  output logic [CH_W-1:0]   adc_ch,
  input  logic              adc_ack,
  input  logic [CODE_W-1:0] adc_code,
  output logic              irq_o,
  output logic              shut_rst_o,
  output logic              shut_gpio_o
);
  logic [1:0]                  rst_sync_q;
  logic                        rst_ni;
  logic                        scan_en, shut_pol, hot, smp_vld;
  logic [CH_N-1:0]             src_en, irq_en, to_gpio, to_rst;
  logic [CH_N-1:0]             over, irq_hit, shut_hit, watched;
  logic [CH_N-1:0][CODE_W-1:0] limit;
  logic [DB_W-1:0]             int_db, shut_db;
  logic [PER_W-1:0]            per_slow, per_fast;
  logic                        srst_q, srst_d, sgpio_q, sgpio_d;
  logic                        srst_act, sgpio_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  tsup_regs #(.CH_N(CH_N), .CODE_W(CODE_W), .PER_W(PER_W), .DB_W(DB_W),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_ni(rst_ni), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .smp_vld(smp_vld), .smp_ch(adc_ch), .smp_code(adc_code),
    .irq_hit(irq_hit), .shut_any(srst_q | sgpio_q),
    .scan_en(scan_en), .shut_pol(shut_pol), .src_en(src_en), .irq_en(irq_en),
    .to_gpio(to_gpio), .to_rst(to_rst), .limit(limit), .int_db(int_db),
    .shut_db(shut_db), .per_slow(per_slow), .per_fast(per_fast), .irq_o(irq_o)
  );

  tsup_sched #(.CH_N(CH_N), .PER_W(PER_W)) u_sched (
    .clk(clk), .rst_ni(rst_ni), .scan_en(scan_en), .hot(hot),
    .per_slow(per_slow), .per_fast(per_fast), .adc_ack(adc_ack),
    .adc_req(adc_req), .adc_ch(adc_ch), .smp_vld(smp_vld)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    tsup_chan #(.CODE_W(CODE_W), .DB_W(DB_W)) u_chan (
      .clk(clk), .rst_ni(rst_ni),
      .smp(smp_vld && adc_ch == CH_W'(g)),
      .code(adc_code), .limit(limit[g]), .int_db(int_db), .shut_db(shut_db),
      .irq_en(irq_en[g]), .src_en(src_en[g]),
      .over_o(over[g]), .irq_hit(irq_hit[g]), .shut_hit(shut_hit[g])
    );
  end

  assign watched = irq_en | src_en;
  assign hot     = |(over & watched);

  always_comb begin
    srst_d  = srst_q  | (|(shut_hit & to_rst));
    sgpio_d = sgpio_q | (|(shut_hit & to_gpio));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q  <= 1'b0;
      sgpio_q <= 1'b0;
    end else begin
      srst_q  <= srst_d;
      sgpio_q <= sgpio_d;
    end
  end

  assign srst_act    = scan_en & srst_q;
  assign sgpio_act   = scan_en & sgpio_q;
  assign shut_rst_o  = shut_pol ? srst_act  : ~srst_act;
  assign shut_gpio_o = shut_pol ? sgpio_act : ~sgpio_act;

  AST_SHUT_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    srst_q |=> srst_q); // R8
  AST_SHUT_GPIO_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    sgpio_q |=> sgpio_q); // R8
  AST_OFF_INACTIVE: assert property (@(posedge clk) disable iff (!rst_ni)
    !scan_en |-> shut_rst_o != shut_pol && shut_gpio_o != shut_pol); // R9
endmodule

// File: tb/thermal_supervisor_tb.sv
module thermal_supervisor_tb;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        adc_req, adc_ack = 1'b0;
  logic [1:0]  adc_ch;
  logic [11:0] adc_code = '0;
  logic        irq_o, shut_rst_o, shut_gpio_o;

  always #5 clk = ~clk;

  thermal_supervisor u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .adc_req(adc_req), .adc_ch(adc_ch), .adc_ack(adc_ack), .adc_code(adc_code),
    .irq_o(irq_o), .shut_rst_o(shut_rst_o), .shut_gpio_o(shut_gpio_o)
  );

  int nchk = 0, nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model: answers a request after a short fixed delay
  logic [11:0] codes [N];
  int  lat = 0, scans = 0, end_cyc = 0, rise_cyc = 0, gap = 0, exp_ch = 0, order_err = 0;
  int  ack_ch = 0;
  logic req_q = 1'b0;
  always @(negedge clk) begin
    if (adc_ack) begin
      adc_ack = 1'b0;
      lat = 0;
      if (ack_ch == N - 1) begin scans++; end_cyc = cyc; end
    end else if (adc_req) begin
      if (!req_q) begin rise_cyc = cyc; gap = cyc - end_cyc; exp_ch = 0; end
      if (lat >= 2) begin
        adc_ack = 1'b1; adc_code = codes[adc_ch]; ack_ch = int'(adc_ch);
        if (int'(adc_ch) != exp_ch) order_err++;
        exp_ch++; lat = 0;
      end else lat++;
    end else lat = 0;
    req_q = adc_req;
  end

  // shadow of the programmed state and expected behaviour
  logic [31:0] m_ctrl, m_ien;
  logic [11:0] m_lim [N];
  int m_idb, m_sdb, m_slow, m_fast, m_cnt [N];
  logic [N-1:0] m_pend, m_over;
  logic m_srst, m_sgpio, touched;
  int seen = 0, wr_cyc = 0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic shadow_reset();
    m_ctrl = 0; m_ien = 0; m_idb = 4; m_sdb = 4; m_slow = 250; m_fast = 50;
    m_pend = 0; m_over = 0; m_srst = 0; m_sgpio = 0; touched = 1;
    for (int i = 0; i < N; i++) begin m_lim[i] = 0; m_cnt[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    shadow_reset();
    seen = scans;
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    wr_cyc = cyc; touched = 1;
    case (a)
      'h04: m_ctrl = d;
      'h08: m_ien = d;
      'h0C: m_pend = m_pend & ~d[N-1:0];
      'h60: m_idb = int'(d[7:0]);
      'h64: m_sdb = int'(d[7:0]);
      'h68: m_slow = int'(d[15:0]);
      'h6C: m_fast = int'(d[15:0]);
      default: for (int i = 0; i < N; i++) if (a == 'h40 + 4 * i) m_lim[i] = d[11:0];
    endcase
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 8'(a);
    @(negedge clk); bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int exp_period();
    logic h = 1'b0;
    int p;
    for (int i = 0; i < N; i++) if (m_over[i] && (m_ien[i] || m_ctrl[4 + i])) h = 1'b1;
    p = h ? m_fast : m_slow;
    return (p == 0) ? 1 : p;
  endfunction

  function automatic logic exp_out(input logic latched);
    logic act = m_ctrl[0] & latched;
    return m_ctrl[8] ? act : ~act;
  endfunction

  // wait for one scan, advance the model, compare the visible state
  task automatic scan_check();
    int egap = exp_period();
    logic t = touched;
    logic [31:0] d;
    while (scans == seen) @(negedge clk);
    seen++;
    touched = 0;
    for (int i = 0; i < N; i++) begin
      logic ov = (codes[i] <= m_lim[i]);
      int ie = (m_idb == 0) ? 1 : m_idb;
      int se = (m_sdb == 0) ? 1 : m_sdb;
      m_cnt[i] = ov ? ((m_cnt[i] < 255) ? m_cnt[i] + 1 : 255) : 0;   // R5
      if (m_ien[i] && ov && m_cnt[i] >= ie) m_pend[i] = 1'b1;
      if (m_ctrl[4 + i] && ov && m_cnt[i] >= se) begin
        if (m_ien[4 + i]) m_sgpio = 1'b1;
        if (m_ien[8 + i]) m_srst = 1'b1;
      end
      m_over[i] = ov;
    end
    if (!t) chk("R10", "scan interval", gap, egap);
    rreg('h0C, d);
    chk("R6", "pending bits", 32'(d[N-1:0]), 32'(m_pend));
    chk("R7", "shutdown status bit", 32'(d[8]), 32'(m_srst | m_sgpio));
    chk("R6", "irq output", 32'(irq_o), 32'(|m_pend));
    chk("R8", "reset shutdown out", 32'(shut_rst_o), 32'(exp_out(m_srst)));
    chk("R8", "pin shutdown out", 32'(shut_gpio_o), 32'(exp_out(m_sgpio)));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R3 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int req_seen;
    void'($urandom(32'h1c3d));
    for (int i = 0; i < N; i++) codes[i] = 12'd3000;
    shadow_reset();
    do_reset();

    // R1 reset values
    rreg('h04, d); chk("R1", "ctrl", d, 0);
    rreg('h08, d); chk("R1", "route", d, 0);
    rreg('h0C, d); chk("R1", "pending", d, 0);
    rreg('h60, d); chk("R1", "irq debounce", d, 4);
    rreg('h64, d); chk("R1", "shut debounce", d, 4);
    rreg('h68, d); chk("R1", "normal interval", d, 250);
    rreg('h6C, d); chk("R1", "fast interval", d, 50);
    chk("R1", "irq", 32'(irq_o), 0);
    chk("R1", "shut outputs", {30'd0, shut_rst_o, shut_gpio_o}, 3);

    // R2 register map read-back
    for (int i = 0; i < N; i++) begin
      wreg('h40 + 4 * i, 32'h100 + 32'(i) * 32'h111);
      rreg('h40 + 4 * i, d); chk("R2", "limit readback", d, 32'h100 + 32'(i) * 32'h111);
    end
    wreg('h60, 3); rreg('h60, d); chk("R2", "debounce readback", d, 3);

    // R3 idle while disabled
    req_seen = 0;
    repeat (300) begin @(negedge clk); if (adc_req) req_seen++; end
    chk("R3", "requests while disabled", req_seen, 0);

    wreg('h68, 60); wreg('h6C, 40); wreg('h64, 3);
    for (int i = 0; i < N; i++) begin wreg('h40 + 4 * i, 2000); codes[i] = 12'(3000 + 100 * i); end
    wreg('h08, 32'h2);
    wreg('h04, 32'h1);
    d = 32'(wr_cyc);
    scan_check();
    chk("R3", "first request delay", rise_cyc - int'(d), 60);
    for (int i = 0; i < N; i++) begin
      logic [31:0] r;
      rreg('h20 + 4 * i, r); chk("R4", "reading register", r, 32'(codes[i]));
    end
    scan_check();

    // R6 debounce to interrupt, R10 fast interval
    codes[1] = 1500; codes[3] = 1000;
    for (int k = 0; k < 3; k++) scan_check();
    chk("R6", "ch1 pending after debounce", 32'(irq_o), 1);
    scan_check();

    // R7 clear pending by writing it back without bit 8
    rreg('h0C, d);
    codes[1] = 3000;
    wreg('h0C, d & ~32'h100);
    rreg('h0C, d); chk("R7", "pending after clear", 32'(d[N-1:0]), 0);
    scan_check();
    scan_check();

    // R5 interrupted hot run must restart the count
    codes[1] = 1500; scan_check(); scan_check();
    codes[1] = 3000; scan_check();
    codes[1] = 1500; scan_check(); scan_check();
    chk("R5", "no pending after broken run", 32'(irq_o), 0);
    codes[1] = 3000; scan_check(); scan_check();

    // R8 shutdown to pin, low-active, sticky; R9 disable forces inactive
    wreg('h08, 32'h2 | 32'h40);
    wreg('h04, 32'h1 | 32'h40);
    codes[2] = 1000;
    scan_check(); scan_check();
    chk("R8", "pin still inactive before debounce", 32'(shut_gpio_o), 1);
    scan_check();
    chk("R8", "pin active low", 32'(shut_gpio_o), 0);
    chk("R8", "reset output untouched", 32'(shut_rst_o), 1);
    codes[2] = 3000;
    scan_check();
    chk("R8", "pin latched after cooling", 32'(shut_gpio_o), 0);
    wreg('h04, 32'h40);
    chk("R9", "inactive while disabled", 32'(shut_gpio_o), 1);
    wreg('h04, 32'h41);
    chk("R9", "active again on enable", 32'(shut_gpio_o), 0);

    // R9 high polarity, R8 reset route
    do_reset();
    wreg('h68, 60); wreg('h6C, 40);
    for (int i = 0; i < N; i++) begin wreg('h40 + 4 * i, 2000); codes[i] = 12'd3000; end
    wreg('h08, 32'h100);
    wreg('h04, 32'h111);
    chk("R9", "high polarity idle level", {30'd0, shut_rst_o, shut_gpio_o}, 0);
    codes[0] = 500;
    for (int k = 0; k < 4; k++) scan_check();
    chk("R8", "reset output active high", 32'(shut_rst_o), 1);
    chk("R8", "pin output untouched", 32'(shut_gpio_o), 0);

    // random phase
    do_reset();
    wreg('h68, 60); wreg('h6C, 40);
    wreg('h60, $urandom_range(1, 4)); wreg('h64, $urandom_range(1, 4));
    for (int i = 0; i < N; i++) wreg('h40 + 4 * i, $urandom_range(1000, 3000));
    wreg('h08, $urandom_range(0, 15) | (32'h400));
    wreg('h04, 32'h1 | (($urandom_range(0, 3) == 0) ? 32'h80 : 32'h0));
    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < N; i++)
        codes[i] = 12'(int'(m_lim[i]) + int'($urandom_range(0, 12)) - 4);
      if ($urandom_range(0, 5) == 0) wreg('h0C, $urandom_range(0, 15));
      scan_check();
    end

    chk("R3", "channel order errors", order_err, 0);
    finish_run();
  end
endmodule